// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects level-sensitive interrupt lines from several dies and offers the CPU one event register. Each line's hardware input is combined with a software-trigger bit, gated by a single mask bit, and fed to a fixed-priority selector. The lowest-numbered pending, unmasked line wins. Lines are numbered die-major: global line = die * LINES_PER_DIE + number within die.

A read of the event register returns the winning line as a die ID plus a number within that die. The same read acknowledges the event and sets that line's mask bit, so no separate acknowledge write exists. After servicing the line, software clears the mask bit through a dedicated mask-clear address. A registered interrupt output tells the CPU that some unmasked request is pending.

The register bus is a byte address with separate write and read strobes. The address holds a 3-bit register kind in bits [ADDR_W-1:ADDR_W-3] and a word index in bits [ADDR_W-4:2]. Word index w covers global lines 32w to 32w+31, with bit b standing for line 32w+b. The kinds are 0 event, 1 soft-trigger set, 2 soft-trigger clear, 3 mask set, 4 mask clear and 5 raw request status. With the default ADDR_W=10, the byte address is kind*128 + index*4.

Top module: `autoack_intc`

## Requirements
- R1: After reset every mask bit is 1 and every soft-trigger bit is 0. irq_o is low, and an event read returns 0.
- R2: The raw request of a line is its hardware input ORed with its soft-trigger bit. A write to kind 1 sets, and a write to kind 2 clears, the soft-trigger bits whose data bits are 1. A read of kind 5 returns the raw requests of that word.
- R3: A masked line never drives irq_o and is never returned by an event read.
- R4: An event read returns the lowest-numbered global line that is pending and unmasked in the cycle of the read.
- R5: An event word has these fields: [31:30] = 0 (hardware type), bit 23 = 1 (valid), [29:24] = die ID and [15:0] = number within the die. All other bits are 0. Read data appears on rd_data_o in the cycle after the read strobe.
- R6: An event read that returns a line sets that line's mask bit at the same clock edge. irq_o falls one cycle later if nothing else is pending.
- R7: An event read with nothing pending returns 0 and changes no mask bit.
- R8: A write to kind 3 sets, and a write to kind 4 clears, the mask bits whose data bits are 1. A read of kind 3 or kind 4 returns the mask word. Kind 1 and kind 2 reads return the soft-trigger word.
- R9: irq_o is a register that holds whether any unmasked request was pending in the previous cycle.
- R10: A hardware line stays pending for as long as it is high. If it is unmasked again while still high, it is delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_hw_i | input | N_DIES*LINES_PER_DIE | Level hardware requests, die-major |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address: kind and word index |
| wr_data_i | input | 32 | Write data, one bit per line |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered CPU interrupt request |

## Verification
The assertions check on every cycle that irq_o follows the pending-and-unmasked state with one register of delay. On every event read they also check that the returned line had no lower-numbered competitor, that its mask bit is set in the following cycle, that the type field stays zero, and that an empty read yields an all-zero word. The bench scenarios are needed for the parts that span several accesses. These are delivery of every single line in turn, the ascending order of back-to-back reads over a mixed request pattern, re-delivery of a line that is still high after software unmasks it, and the soft-trigger and mask set/clear paths as seen through readback.

// File: rtl/autoack_pkg.sv
package autoack_pkg;

  typedef enum logic [2:0] {
    K_EVENT = 3'd0,
    K_SWSET = 3'd1,
    K_SWCLR = 3'd2,
    K_MSET  = 3'd3,
    K_MCLR  = 3'd4,
    K_PEND  = 3'd5
  } reg_kind_e;

  localparam int WORD_W = 32;

  typedef struct packed {
    logic [1:0]  ev_type;
    logic [5:0]  die;
    logic        valid;
    logic [6:0]  rsvd;
    logic [15:0] num;
  } event_word_t;

endpackage

// File: rtl/autoack_prio.sv
module autoack_prio #(
  parameter int N  = 64,
  parameter int LW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [LW-1:0] idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = LW'(i);
      end
    end
  end

endmodule

// File: rtl/autoack_bank.sv
module autoack_bank
  import autoack_pkg::*;
#(
  parameter int N     = 64,
  parameter int LW    = 6,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  reg_kind_e        wr_kind_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic             ack_valid_i,
  input  logic [LW-1:0]    ack_line_i,
  output logic [N-1:0]     sw_q_o,
  output logic [N-1:0]     mask_q_o
);

  for (genvar g = 0; g < N; g++) begin : g_line
    localparam int WI = g / WORD_W;
    localparam int BI = g % WORD_W;
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(WI)) && wr_data_i[BI];

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        sw_q_o[g]   <= 1'b0;
        mask_q_o[g] <= 1'b1;
      end else begin
        if (hit && wr_kind_i == K_SWSET) sw_q_o[g] <= 1'b1;
        if (hit && wr_kind_i == K_SWCLR) sw_q_o[g] <= 1'b0;
        if (hit && wr_kind_i == K_MSET)  mask_q_o[g] <= 1'b1;
        if (hit && wr_kind_i == K_MCLR)  mask_q_o[g] <= 1'b0;
        if (ack_valid_i && ack_line_i == LW'(g)) mask_q_o[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/autoack_intc.sv
module autoack_intc
  import autoack_pkg::*;
#(
  parameter int N_DIES        = 2,
  parameter int LINES_PER_DIE = 32,
  parameter int ADDR_W        = 10
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic [N_DIES*LINES_PER_DIE-1:0] irq_hw_i,
  input  logic                            wr_en_i,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [31:0]                     wr_data_i,
  output logic [31:0]                     rd_data_o,
  output logic                            irq_o
);

  localparam int N      = N_DIES * LINES_PER_DIE;
  localparam int LW     = (N > 1) ? $clog2(N) : 1;
  localparam int NWORDS = (N + WORD_W - 1) / WORD_W;
  localparam int IDX_W  = ADDR_W - 5;
  localparam int PAD_W  = NWORDS * WORD_W;

  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             unused_lsb;
  assign kind       = reg_kind_e'(addr_i[ADDR_W-1 -: 3]);
  assign idx        = addr_i[ADDR_W-4:2];
  assign unused_lsb = ^addr_i[1:0];

  logic [N-1:0]  sw_q, mask_q, raw_req, pend_w;
  logic          win_found;
  logic [LW-1:0] win_idx;
  logic          ev_rd, ack_valid;

  assign raw_req   = irq_hw_i | sw_q;
  assign pend_w    = raw_req & ~mask_q;
  assign ev_rd     = rd_en_i && (kind == K_EVENT);
  assign ack_valid = ev_rd && win_found;

  autoack_prio #(.N(N), .LW(LW)) prio_i (
    .req_i   (pend_w),
    .found_o (win_found),
    .idx_o   (win_idx)
  );

  autoack_bank #(.N(N), .LW(LW), .IDX_W(IDX_W)) bank_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .wr_kind_i   (kind),
    .wr_idx_i    (idx),
    .wr_data_i   (wr_data_i),
    .ack_valid_i (ack_valid),
    .ack_line_i  (win_idx),
    .sw_q_o      (sw_q),
    .mask_q_o    (mask_q)
  );

  event_word_t ev_word;
  always_comb begin
    int unsigned line;
    line    = 32'(win_idx);
    ev_word = '0;
    if (win_found) begin
      ev_word.valid = 1'b1;
      ev_word.die   = 6'(line / LINES_PER_DIE);
      ev_word.num   = 16'(line % LINES_PER_DIE);
    end
  end

  logic [PAD_W-1:0] sw_pad, mask_pad, raw_pad;
  always_comb begin
    sw_pad   = '0;
    mask_pad = '0;
    raw_pad  = '0;
    sw_pad[N-1:0]   = sw_q;
    mask_pad[N-1:0] = mask_q;
    raw_pad[N-1:0]  = raw_req;
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (kind == K_EVENT) begin
      rd_next = ev_word;
    end else if (32'(idx) < NWORDS) begin
      case (kind)
        K_SWSET, K_SWCLR: rd_next = sw_pad[32'(idx)*WORD_W +: WORD_W];
        K_MSET, K_MCLR:   rd_next = mask_pad[32'(idx)*WORD_W +: WORD_W];
        K_PEND:           rd_next = raw_pad[32'(idx)*WORD_W +: WORD_W];
        default:          rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_next;
      irq_o <= |pend_w;
    end
  end

endmodule

// File: rtl/autoack_chk.sv
module autoack_chk #(
  parameter int N_DIES        = 2,
  parameter int LINES_PER_DIE = 32,
  parameter int ADDR_W        = 10
) (
  input logic                            clk_i,
  input logic                            rst_i,
  input logic                            rd_en_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [31:0]                     rd_data_o,
  input logic                            irq_o,
  input logic [N_DIES*LINES_PER_DIE-1:0] pend_w,
  input logic [N_DIES*LINES_PER_DIE-1:0] mask_q
);

  localparam int N = N_DIES * LINES_PER_DIE;

  logic ev_rd;
  assign ev_rd = rd_en_i && (addr_i[ADDR_W-1 -: 3] == 3'd0);

  logic [N-1:0] sel, below;
  always_comb begin
    int unsigned line;
    line = 32'(rd_data_o[29:24]) * LINES_PER_DIE + 32'(rd_data_o[15:0]);
    for (int i = 0; i < N; i++) begin
      sel[i]   = (32'(i) == line);
      below[i] = (32'(i) < line);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (!irq_o && rd_data_o == 32'd0)); // R1

  AST_EV_TYPE_HW: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_rd |=> rd_data_o[31:30] == 2'b00); // R5

  AST_EV_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev_rd && pend_w == '0) |=> rd_data_o == 32'd0); // R7

  AST_EV_DELIVERS: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev_rd && pend_w != '0) |=> rd_data_o[23]); // R3

  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_rd |=> (!rd_data_o[23] ||
               ((($past(pend_w) & below) == '0) && (($past(pend_w) & sel) != '0)))); // R4

  AST_ACK_MASKS: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_rd |=> (!rd_data_o[23] || ((mask_q & sel) != '0))); // R6

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_w != '0) |=> irq_o); // R9

  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_w == '0) |=> !irq_o); // R9

endmodule

bind autoack_intc autoack_chk #(
  .N_DIES(N_DIES), .LINES_PER_DIE(LINES_PER_DIE), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .pend_w    (pend_w),
  .mask_q    (mask_q)
);

// File: tb/autoack_intc_tb_top.sv
`timescale 1ns/1ps
module autoack_intc_tb_top;

  localparam int ND = 2;
  localparam int L  = 32;
  localparam int N  = ND * L;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  hw = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  autoack_intc #(.N_DIES(ND), .LINES_PER_DIE(L), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_i(rst), .irq_hw_i(hw), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] mk_addr(int kind, int idx);
    return AW'(kind * 128 + idx * 4);
  endfunction

  function automatic logic [31:0] exp_ev(int g);
    return {2'b00, 6'(g / L), 1'b1, 7'd0, 16'(g % L)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int kind, int idx, logic [31:0] d);
    @(negedge clk);
    addr = mk_addr(kind, idx); wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int kind, int idx, output logic [31:0] d);
    @(negedge clk);
    addr = mk_addr(kind, idx); rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] pat;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    for (int w = 0; w < N / 32; w++) begin
      rd(3, w, d); check("R1 mask", d, 32'hffff_ffff);
      rd(1, w, d); check("R1 sw", d, 32'd0);
    end
    rd(0, 0, d); check("R1 event", d, 32'd0);

    // R5 R6 R9 R7: every line delivered alone
    for (int g = 0; g < N; g++) begin
      hw = '0; hw[g] = 1'b1;
      wr(4, g / 32, 32'(1) << (g % 32));
      idle(2);
      check("R9 irq up", 32'(irq), 32'd1);
      rd(0, 0, d); check("R5 event word", d, exp_ev(g));
      idle(2);
      check("R6 irq down", 32'(irq), 32'd0);
      rd(3, g / 32, d); check("R6 mask set", d, 32'hffff_ffff);
      rd(0, 0, d); check("R7 empty after ack", d, 32'd0);
      hw = '0;
    end

    // R3 masked lines stay silent, R7 empty read leaves masks
    hw = '1;
    idle(3);
    check("R3 irq masked", 32'(irq), 32'd0);
    rd(0, 0, d); check("R3 event masked", d, 32'd0);
    for (int w = 0; w < N / 32; w++) begin
      rd(4, w, d); check("R7 masks kept", d, 32'hffff_ffff);
    end
    hw = '0;

    // R4 back-to-back reads over a mixed pattern
    pat = '0;
    pat[63] = 1'b1; pat[5] = 1'b1; pat[40] = 1'b1; pat[9] = 1'b1; pat[33] = 1'b1; pat[31] = 1'b1;
    hw = pat;
    for (int w = 0; w < N / 32; w++) wr(4, w, 32'hffff_ffff);
    @(negedge clk);
    addr = mk_addr(0, 0); rd_en = 1'b1;
    for (int g = 0; g < N; g++) begin
      if (pat[g]) begin
        @(posedge clk);
        @(negedge clk);
        check("R4 priority order", rdata, exp_ev(g));
      end
    end
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    check("R4 drained", rdata, 32'd0);
    hw = '0;

    // R10 re-delivery while still high
    hw[12] = 1'b1;
    rd(0, 0, d); check("R10 first", d, exp_ev(12));
    rd(0, 0, d); check("R10 masked", d, 32'd0);
    wr(4, 0, 32'h0000_1000);
    rd(0, 0, d); check("R10 again", d, exp_ev(12));
    hw = '0;

    // R2 software trigger
    for (int w = 0; w < N / 32; w++) wr(3, w, 32'hffff_ffff);
    wr(1, 1, 32'h0000_0100);
    rd(5, 1, d); check("R2 raw from sw", d, 32'h0000_0100);
    rd(1, 1, d); check("R2 sw readback", d, 32'h0000_0100);
    wr(4, 1, 32'h0000_0100);
    rd(0, 0, d); check("R2 sw event", d, exp_ev(40));
    wr(2, 1, 32'h0000_0100);
    rd(5, 1, d); check("R2 sw cleared", d, 32'd0);
    hw[2] = 1'b1;
    wr(1, 0, 32'h0000_0008);
    rd(5, 0, d); check("R2 raw or", d, 32'h0000_000c);
    wr(4, 0, 32'h0000_000c);
    rd(0, 0, d); check("R2 hw beats sw", d, exp_ev(2));
    rd(0, 0, d); check("R2 sw next", d, exp_ev(3));
    wr(2, 0, 32'h0000_0008);
    hw = '0;

    // R8 mask set/clear readback
    wr(4, 0, 32'h00ff_00f0);
    rd(3, 0, d); check("R8 clear", d, 32'hff00_ff0f);
    wr(3, 0, 32'h0000_00a0);
    rd(4, 0, d); check("R8 set", d, 32'hff00_ffaf);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule